// File: doc/BRIEF.md
# Delayed Branch Program Sequencer

This block sequences instruction addresses for a three-stage fetch, decode and execute pipeline. Each cycle it presents one fetch address to a synchronous program memory. The memory returns the opcode and target fields one cycle later. The block reports which program address is currently in the execute stage.

Jump, call and return all take effect with two delay slots. The two words that follow a branch still execute while the new stream is fetched, so the pipeline never drains. A call saves the address three past itself on an internal return stack, and a return resumes from the address it pops from that stack.

Top module: `dbr_sequencer`

## Requirements
- R1: While `rst_n` is low, `fetch_addr` is 0, `exe_valid`, `slot_err`, `stk_ovf` and `stk_unf` are 0, the pipeline holds only bubbles and the return stack is empty. After release, address 0 is the first to execute.
- R2: Instruction encoding on `ins_op`: 00 is a plain instruction, 01 is a jump, 10 is a call and 11 is a return. `ins_target` carries the jump or call destination. In the absence of branches, one instruction executes per cycle, and `exe_pc` rises by one each cycle after the pipeline fills.
- R3: A jump at N executes N, then N+1, then N+2, then the target J. `fetch_addr` shows J in the cycle in which N+1 executes.
- R4: A call behaves like a jump and also pushes N+3 onto the return stack.
- R5: A return at N executes N+1 and N+2, then the popped address R. `fetch_addr` shows R in the cycle in which N+1 executes.
- R6: The stack holds eight return addresses. Eight nested calls followed by eight returns unwind in last-in, first-out order without raising a flag.
- R7: A call made while the stack is full still branches, but its return address is discarded and `stk_ovf` sets and stays set until reset.
- R8: A return on an empty stack does not redirect: execution continues sequentially and `stk_unf` sets and stays set until reset. The two following instructions still count as its delay slots.
- R9: A branch that occupies a delay slot is illegal. It executes as a plain instruction with no redirect, push or pop, and `slot_err` is high during the cycle in which it executes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_addr | output | AW | Address sent to program memory |
| ins_op | input | 2 | Opcode read from memory for the previous fetch address |
| ins_target | input | AW | Branch destination read with the opcode |
| exe_valid | output | 1 | The execute stage holds an instruction |
| exe_pc | output | AW | Address of the instruction in execute |
| slot_err | output | 1 | The instruction in execute is a branch that was ignored because it sat in a delay slot |
| stk_ovf | output | 1 | Sticky flag: a call was made with the stack full |
| stk_unf | output | 1 | Sticky flag: a return was made with the stack empty |

## Verification
The assertions check on every cycle that the execute address advances by one unless a redirect occurred three cycles earlier, and in that case that it equals the redirect address. They also check that the fetch address follows a redirect on the next cycle, that the stack pointer stays within its depth, that a legal call grows the stack, that both stack flags are sticky, and that an ignored branch never redirects. Only the bench scenarios can show that the popped addresses match the calls in last-in, first-out order across eight levels, that discarded pushes and ignored slot branches leave later returns unaffected, and that the whole executed trace matches an architectural model.

// File: rtl/dbr_sequencer.sv
module dbr_sequencer #(
  parameter int AW    = 12,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] fetch_addr,
  input  logic [1:0]    ins_op,
  input  logic [AW-1:0] ins_target,
  output logic          exe_valid,
  output logic [AW-1:0] exe_pc,
  output logic          slot_err,
  output logic          stk_ovf,
  output logic          stk_unf
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  localparam logic [1:0] OP_JMP = 2'b01;
  localparam logic [1:0] OP_CALL = 2'b10;
  localparam logic [1:0] OP_RET = 2'b11;

  logic          dec_valid;
  logic [AW-1:0] dec_pc;
  logic [1:0]    slots;
  logic [1:0]    ex_op;
  logic [AW-1:0] ex_tgt;
  logic [AW-1:0] stk [DEPTH];
  logic [SPW-1:0] sp;

  logic dec_br, dec_bad, is_call, is_ret, push_ok, pop_ok, redir;
  logic [AW-1:0] redir_addr;
  logic [IW-1:0] top_idx, push_idx;

  assign dec_br   = dec_valid && (ins_op != 2'b00);
  assign dec_bad  = dec_br && (slots != 2'd0);
  assign is_call  = exe_valid && (ex_op == OP_CALL);
  assign is_ret   = exe_valid && (ex_op == OP_RET);
  assign push_ok  = is_call && (sp != SPW'(DEPTH));
  assign pop_ok   = is_ret && (sp != '0);
  assign redir    = (exe_valid && (ex_op == OP_JMP)) || is_call || pop_ok;
  assign top_idx  = IW'(sp - 1'b1);
  assign push_idx = IW'(sp);
  assign redir_addr = is_ret ? stk[top_idx] : ex_tgt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_addr <= '0;
      dec_valid  <= 1'b0;
      dec_pc     <= '0;
      slots      <= 2'd0;
      exe_valid  <= 1'b0;
      exe_pc     <= '0;
      ex_op      <= 2'b00;
      ex_tgt     <= '0;
      slot_err   <= 1'b0;
    end else begin
      fetch_addr <= redir ? redir_addr : fetch_addr + 1'b1;
      dec_valid  <= 1'b1;
      dec_pc     <= fetch_addr;
      if (dec_valid) begin
        if (dec_br && !dec_bad) slots <= 2'd2;
        else if (slots != 2'd0) slots <= slots - 2'd1;
      end
      exe_valid <= dec_valid;
      exe_pc    <= dec_pc;
      ex_op     <= (dec_valid && !dec_bad) ? ins_op : 2'b00;
      ex_tgt    <= ins_target;
      slot_err  <= dec_bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp      <= '0;
      stk_ovf <= 1'b0;
      stk_unf <= 1'b0;
    end else begin
      if (push_ok) sp <= sp + 1'b1;
      else if (pop_ok) sp <= sp - 1'b1;
      if (is_call && !push_ok) stk_ovf <= 1'b1;
      if (is_ret && !pop_ok) stk_unf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && push_ok) stk[push_idx] <= exe_pc + AW'(3);
  end
endmodule

// File: rtl/dbr_sequencer_chk.sv
module dbr_sequencer_chk #(
  parameter int AW    = 12,
  parameter int DEPTH = 8,
  parameter int SPW   = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] fetch_addr,
  input logic          exe_valid,
  input logic [AW-1:0] exe_pc,
  input logic          slot_err,
  input logic          stk_ovf,
  input logic          stk_unf,
  input logic [SPW-1:0] sp,
  input logic          redir,
  input logic [AW-1:0] redir_addr,
  input logic          push_ok
);
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    exe_valid && $past(exe_valid) && !$past(redir, 3) |-> exe_pc == $past(exe_pc) + 1'b1);
  a_r3_target: assert property (@(posedge clk) disable iff (!rst_n)
    exe_valid && $past(redir, 3) |-> exe_pc == $past(redir_addr, 3));
  a_r3_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    redir |=> fetch_addr == $past(redir_addr));
  a_r4_push: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> sp == $past(sp) + 1'b1);
  a_r6_sp_range: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SPW'(DEPTH));
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stk_ovf |=> stk_ovf);
  a_r8_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stk_unf |=> stk_unf);
  a_r9_no_redir: assert property (@(posedge clk) disable iff (!rst_n)
    slot_err |-> !redir);
endmodule

bind dbr_sequencer dbr_sequencer_chk #(.AW(AW), .DEPTH(DEPTH), .SPW(SPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .exe_valid(exe_valid),
  .exe_pc(exe_pc), .slot_err(slot_err), .stk_ovf(stk_ovf), .stk_unf(stk_unf),
  .sp(sp), .redir(redir), .redir_addr(redir_addr), .push_ok(push_ok)
);

// File: tb/test_dbr_sequencer.sv
`timescale 1ns/1ps
module test_dbr_sequencer;
  localparam int AW = 12;
  logic clk = 0, rst_n = 0;
  logic [AW-1:0] fetch_addr, exe_pc, ins_target;
  logic [1:0] ins_op;
  logic exe_valid, slot_err, stk_ovf, stk_unf;
  int checks = 0, failures = 0;

  logic [1:0]    mop [256];
  logic [AW-1:0] mtg [256];

  always #2 clk = ~clk;

  dbr_sequencer #(.AW(AW), .DEPTH(8)) i_dbr_sequencer (
    .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .ins_op(ins_op),
    .ins_target(ins_target), .exe_valid(exe_valid), .exe_pc(exe_pc),
    .slot_err(slot_err), .stk_ovf(stk_ovf), .stk_unf(stk_unf));

  always @(posedge clk) begin
    ins_op     <= mop[fetch_addr[7:0]];
    ins_target <= mtg[fetch_addr[7:0]];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) begin mop[i] = 2'b00; mtg[i] = '0; end
  endtask

  task automatic put(input int a, input logic [1:0] op, input int t);
    mop[a] = op; mtg[a] = AW'(t);
  endtask

  task automatic run(input string tag, input int n);
    int mpc, cnt, mtgt, execs, nxt;
    bit pend, movf, munf, efv, merr;
    int efa;
    int stq[$];
    logic [1:0] op;
    mpc = 0; cnt = 0; mtgt = 0; pend = 0; movf = 0; munf = 0; efv = 0; efa = 0; execs = 0;
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    chk(fetch_addr == 0, "R1 fetch in reset", fetch_addr, 0);
    chk(exe_valid == 0 && slot_err == 0, "R1 execute empty in reset", exe_valid, 0);
    chk(stk_ovf == 0 && stk_unf == 0, "R1 flags in reset", {stk_ovf, stk_unf}, 0);
    rst_n = 1;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (efv) begin
        chk(fetch_addr == AW'(efa), {tag, " R3/R5 fetch redirect"}, fetch_addr, efa);
        efv = 0;
      end
      if (exe_valid) begin
        execs++;
        op = mop[mpc % 256];
        merr = (op != 2'b00) && cnt > 0;
        chk(exe_pc == AW'(mpc), {tag, " trace"}, exe_pc, mpc);
        chk(slot_err == merr, {tag, " R9 slot flag"}, slot_err, merr);
        chk(stk_ovf == movf, {tag, " R7 overflow flag"}, stk_ovf, movf);
        chk(stk_unf == munf, {tag, " R8 underflow flag"}, stk_unf, munf);
        if (cnt > 0) begin
          cnt--;
          nxt = (cnt == 0 && pend) ? mtgt : mpc + 1;
          if (cnt == 0) pend = 0;
        end else begin
          nxt = mpc + 1;
          if (op != 2'b00) begin
            cnt = 2; pend = 1;
            mtgt = int'(mtg[mpc % 256]);
            if (op == 2'b10) begin
              if (stq.size() < 8) stq.push_back((mpc + 3) % 4096); else movf = 1;
            end else if (op == 2'b11) begin
              if (stq.size() > 0) mtgt = stq.pop_back();
              else begin munf = 1; pend = 0; end
            end
            if (pend) begin efv = 1; efa = mtgt; end
          end
        end
        mpc = nxt % 4096;
      end
    end
    chk(execs == n - 1, {tag, " R2 one instruction per cycle"}, execs, n - 1);
  endtask

  initial begin
    ins_op = 2'b00; ins_target = '0;
    clear_mem();
    put(5, 2'b01, 20); put(25, 2'b01, 5);
    run("R1/R2/R3 jumps", 40);

    clear_mem();
    for (int k = 0; k < 8; k++) begin
      put(8 * k, 2'b10, 8 * (k + 1));
      if (k > 0) put(8 * k + 3, 2'b11, 0);
    end
    put(64, 2'b11, 0);
    put(3, 2'b01, 100); put(100, 2'b01, 100);
    run("R4/R5/R6 nested", 130);

    clear_mem();
    put(0, 2'b01, 50); put(50, 2'b10, 50);
    run("R7 overflow", 60);

    clear_mem();
    put(0, 2'b11, 0); put(4, 2'b01, 30); put(5, 2'b01, 60); put(6, 2'b10, 70);
    put(30, 2'b10, 40); put(40, 2'b11, 0); put(33, 2'b01, 33);
    run("R8/R9 underflow and slots", 50);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #80000;
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule